// File: doc/BRIEF.md
# Word-Addressed Serial Port with Programmable Bit Divisor

This block is a small serial port that sits on a simple single-cycle register bus. Software sends a byte by writing it to the transmit data word once the status word reports that the one-byte holding slot is free. The block moves that byte into a shifter and sends it as an 8N1 frame: a low start bit, eight data bits least significant first, and a high stop bit. The line idles high.

Incoming frames are captured by a receiver that synchronises the serial input through two flip-flops. It measures from the detected falling edge to the middle of each bit and stores the finished byte in a one-byte receive register. The status word reports that a byte is waiting. It also reports an overrun, where a byte was lost to a newer one, and a framing error, where the stop bit was sampled low.

The bit time is set by a divisor register that holds the number of system clocks per bit minus one. To get a given rate, software programs the clock frequency divided by the baud rate, minus one. A control word and an end-of-packet word are plain read/write storage.

Top module: `mmio_uart`

## Requirements
- R1: Word offsets on `bus_addr` are 0 receive data, 1 transmit data, 2 status, 3 control, 4 divisor, 5 end-of-packet. Control, divisor (low DIV_W bits) and end-of-packet read back what was written. A read presents its data on `bus_rdata` at the clock edge of the access, and `bus_rdata` holds its value while no read is made.
- R2: After reset the status word reads 0x60 (bits 6 and 5 set, all others 0), the divisor reads DEF_DIV, and control and end-of-packet read 0.
- R3: The transmitter sends 8N1 frames, least significant bit first, on `txd`, which idles high. Each bit lasts divisor+1 clock cycles.
- R4: Status bit 6 (tx ready) is 1 when the holding slot is free. An accepted write to transmit data clears it until the byte moves into the shifter.
- R5: Status bit 5 (tx empty) is 1 only when the holding slot is free and the shifter is idle. It stays 0 until the stop bit of the last frame has ended.
- R6: A write to transmit data while tx ready is 0 is ignored, so no extra frame is sent.
- R7: A valid 8N1 frame on `rxd` stores its byte in receive data bits [7:0] (upper bits read 0) and sets status bit 7 (rx ready).
- R8: Reading receive data clears rx ready.
- R9: A frame that completes while rx ready is still 1 overwrites the held byte and sets status bit 3 (overrun). Any write to status clears bits 3 and 2.
- R10: A low pulse on `rxd` that is high again at the middle of the start bit is discarded, and no byte is stored.
- R11: A stop bit sampled low sets status bit 2 (framing error), and the byte is still stored with rx ready set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line, asynchronous |

## Verification
The assertions check the following on every cycle:
- `txd` is high whenever tx empty is reported.
- tx empty implies tx ready.
- An ignored transmit write leaves the holding byte unchanged.
- A receive-data read clears rx ready unless a frame lands in the same cycle.
- A frame landing on an unread byte raises overrun.
- Read data stays steady between reads.

Only the bench scenarios can show the rest:
- Bit order and bit width on the serial lines, across several divisors.
- The mid-bit sampling that rejects a short start glitch.
- Framing-error capture.
- That an ignored write really produces no extra frame.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam int OFS_RXDATA = 0;
  localparam int OFS_TXDATA = 1;
  localparam int OFS_STATUS = 2;
  localparam int OFS_CTRL   = 3;
  localparam int OFS_DIV    = 4;
  localparam int OFS_EOP    = 5;

  localparam int ST_RXRDY = 7;
  localparam int ST_TXRDY = 6;
  localparam int ST_TXEMP = 5;
  localparam int ST_OVR   = 3;
  localparam int ST_FERR  = 2;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
endpackage

// File: rtl/uart_tx_path.sv
module uart_tx_path #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  input  logic             load,
  input  logic [7:0]       din,
  output logic             hold_full,
  output logic [7:0]       hold_q,
  output logic             busy,
  output logic             txd
);
  localparam int BITS = 10;
  localparam int BN_W = $clog2(BITS);

  logic [8:0]       sh;
  logic [DIV_W-1:0] cnt;
  logic [BN_W-1:0]  bitn;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
      busy      <= 1'b0;
      sh        <= '1;
      cnt       <= '0;
      bitn      <= '0;
      txd       <= 1'b1;
    end else begin
      if (load) begin
        hold_full <= 1'b1;
        hold_q    <= din;
      end
      if (!busy) begin
        if (hold_full) begin
          busy      <= 1'b1;
          hold_full <= 1'b0;
          sh        <= {1'b1, hold_q};
          txd       <= 1'b0;
          cnt       <= '0;
          bitn      <= '0;
        end
      end else if (cnt == div) begin
        cnt <= '0;
        if (bitn == BN_W'(BITS - 1)) begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end else begin
          txd  <= sh[0];
          sh   <= {1'b1, sh[8:1]};
          bitn <= bitn + 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_rx_path.sv
module uart_rx_path
  import uart_regs_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  input  logic             rxd,
  output logic             done,
  output logic [7:0]       byte_q,
  output logic             stop_bad
);
  rx_state_t        st;
  logic             s1, s2;
  logic [DIV_W-1:0] cnt;
  logic [2:0]       bitn;
  logic [7:0]       sh;
  logic [DIV_W-1:0] half;

  assign half = div >> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= RX_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      sh       <= '0;
      done     <= 1'b0;
      byte_q   <= '0;
      stop_bad <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        RX_IDLE: if (!s2) begin
          st  <= RX_START;
          cnt <= '0;
        end
        RX_START: if (cnt == half) begin
          cnt  <= '0;
          bitn <= '0;
          st   <= s2 ? RX_IDLE : RX_DATA;
        end else cnt <= cnt + 1'b1;
        RX_DATA: if (cnt == div) begin
          cnt  <= '0;
          sh   <= {s2, sh[7:1]};
          bitn <= bitn + 1'b1;
          if (bitn == 3'd7) st <= RX_STOP;
        end else cnt <= cnt + 1'b1;
        default: if (cnt == div) begin
          done     <= 1'b1;
          byte_q   <= sh;
          stop_bad <= !s2;
          st       <= RX_IDLE;
        end else cnt <= cnt + 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/mmio_uart.sv
module mmio_uart
  import uart_regs_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3,
  parameter int DIV_W   = 16,
  parameter int DEF_DIV = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              txd,
  input  logic              rxd
);
  logic [DATA_W-1:0] ctrl_q, eop_q, status_w;
  logic [DIV_W-1:0]  div_q;
  logic [7:0]        rx_buf, hold_data, rx_byte;
  logic              rx_ready, ovr, ferr;
  logic              hold_full, tx_busy, tx_ready, tx_empty;
  logic              tx_load, rx_done, rx_stop_bad, rd_rx, wr_st;

  assign tx_ready = !hold_full;
  assign tx_empty = !hold_full && !tx_busy;
  assign tx_load  = bus_wr && (bus_addr == ADDR_W'(OFS_TXDATA)) && tx_ready;
  assign rd_rx    = bus_rd && (bus_addr == ADDR_W'(OFS_RXDATA));
  assign wr_st    = bus_wr && (bus_addr == ADDR_W'(OFS_STATUS));

  uart_tx_path #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst(rst), .div(div_q), .load(tx_load), .din(bus_wdata[7:0]),
    .hold_full(hold_full), .hold_q(hold_data), .busy(tx_busy), .txd(txd)
  );

  uart_rx_path #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst(rst), .div(div_q), .rxd(rxd),
    .done(rx_done), .byte_q(rx_byte), .stop_bad(rx_stop_bad)
  );

  always_comb begin
    status_w           = '0;
    status_w[ST_RXRDY] = rx_ready;
    status_w[ST_TXRDY] = tx_ready;
    status_w[ST_TXEMP] = tx_empty;
    status_w[ST_OVR]   = ovr;
    status_w[ST_FERR]  = ferr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      eop_q    <= '0;
      div_q    <= DIV_W'(DEF_DIV);
      rx_buf   <= '0;
      rx_ready <= 1'b0;
      ovr      <= 1'b0;
      ferr     <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == ADDR_W'(OFS_CTRL)) ctrl_q <= bus_wdata;
      if (bus_wr && bus_addr == ADDR_W'(OFS_EOP))  eop_q  <= bus_wdata;
      if (bus_wr && bus_addr == ADDR_W'(OFS_DIV))  div_q  <= bus_wdata[DIV_W-1:0];
      if (wr_st) begin
        ovr  <= 1'b0;
        ferr <= 1'b0;
      end
      if (rd_rx) rx_ready <= 1'b0;
      if (rx_done) begin
        rx_buf   <= rx_byte;
        rx_ready <= 1'b1;
        if (rx_ready && !rd_rx) ovr <= 1'b1;
        if (rx_stop_bad) ferr <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      case (int'(bus_addr))
        OFS_RXDATA: bus_rdata <= DATA_W'(rx_buf);
        OFS_STATUS: bus_rdata <= status_w;
        OFS_CTRL:   bus_rdata <= ctrl_q;
        OFS_DIV:    bus_rdata <= DATA_W'(div_q);
        OFS_EOP:    bus_rdata <= eop_q;
        default:    bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mmio_uart_checker.sv
module mmio_uart_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              txd,
  input logic              tx_ready,
  input logic              tx_empty,
  input logic [7:0]        hold_data,
  input logic              rx_done,
  input logic              rx_ready,
  input logic              ovr
);
  a_r5_idle_line_high: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> txd);

  a_r5_empty_implies_ready: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> tx_ready);

  a_r6_ignored_write_keeps_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(1) && !tx_ready) |=> $stable(hold_data));

  a_r8_read_clears_ready: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(0) && !rx_done) |=> !rx_ready);

  a_r9_overrun_raised: assert property (@(posedge clk) disable iff (rst)
    (rx_done && rx_ready && !(bus_rd && bus_addr == ADDR_W'(0))) |=> ovr);

  a_r1_rdata_holds: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd && !$past(rst)) |=> $stable(bus_rdata));
endmodule

bind mmio_uart mmio_uart_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty),
  .hold_data(hold_data), .rx_done(rx_done), .rx_ready(rx_ready), .ovr(ovr)
);

// File: tb/mmio_uart_test.sv
module mmio_uart_test;
  localparam int DW = 32;
  localparam int AW = 3;
  localparam int DEFD = 15;

  logic clk = 0, rst = 1;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic txd;
  logic rxd = 1;

  int tests = 0, fails = 0;
  int cur_div = DEFD;
  bit finished = 0;

  mmio_uart #(.DATA_W(DW), .ADDR_W(AW), .DIV_W(16), .DEF_DIV(DEFD)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .txd(txd), .rxd(rxd)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] exp_status(bit rr, bit tr, bit te, bit ov, bit fe);
    return {rr, tr, te, 1'b0, ov, fe, 2'b00};
  endfunction

  task automatic check(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(int a, logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(int a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic set_div(int d);
    wr(4, DW'(d));
    cur_div = d;
  endtask

  // capture one frame from txd, aligned on its falling edge
  task automatic tx_capture(output logic [7:0] b, output logic stopv);
    int t = 0;
    logic prev = 1;
    forever begin
      @(negedge clk);
      if (prev && !txd) break;
      prev = txd;
      t++;
      if (t > 5000) begin
        b = 'x; stopv = 'x;
        return;
      end
    end
    repeat ((cur_div + 1) / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (cur_div + 1) @(negedge clk);
      b[i] = txd;
    end
    repeat (cur_div + 1) @(negedge clk);
    stopv = txd;
  endtask

  task automatic rx_send(logic [7:0] b, logic stopv);
    @(negedge clk);
    rxd = 0;
    repeat (cur_div + 1) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (cur_div + 1) @(negedge clk);
    end
    rxd = stopv;
    repeat (cur_div + 1) @(negedge clk);
    rxd = 1;
    repeat (cur_div + 6) @(negedge clk);
  endtask

  initial begin
    int wd = 0;
    while (!finished) begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        fails++; tests++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [DW-1:0] r;
    logic [7:0] b1, b2, rb;
    logic sv1, sv2;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;

    // R2 reset values
    rd(2, r); check("R2 status", r, 32'h60);
    rd(4, r); check("R2 divisor", r, DEFD);
    rd(3, r); check("R2 control", r, 0);
    rd(5, r); check("R2 eop", r, 0);

    // R1 storage registers and hold of read data
    wr(3, 32'hA5A5_0F0F); wr(5, 32'h1234_5678);
    rd(3, r); check("R1 control", r, 32'hA5A5_0F0F);
    rd(5, r); check("R1 eop", r, 32'h1234_5678);
    repeat (3) @(negedge clk);
    check("R1 rdata hold", bus_rdata, 32'h1234_5678);

    // R4 R5 R6 back-to-back transmit with ignored third write
    set_div(7);
    fork
      begin
        tx_capture(b1, sv1);
        tx_capture(b2, sv2);
      end
      begin
        wr(1, 32'h3C);
        repeat (3) @(negedge clk);
        rd(2, r); check("R5 busy shifter", r, DW'(exp_status(0, 1, 0, 0, 0)));
        wr(1, 32'hC3);
        rd(2, r); check("R4 holding full", r, DW'(exp_status(0, 0, 0, 0, 0)));
        wr(1, 32'hFF);
      end
    join
    check("R3 first frame", b1, 8'h3C);
    check("R3 first stop", sv1, 1);
    check("R6 second frame kept", b2, 8'hC3);
    begin
      int lows = 0;
      for (int i = 0; i < 12 * 8; i++) begin
        @(negedge clk);
        if (!txd) lows++;
      end
      check("R6 no extra frame", lows, 0);
    end
    rd(2, r); check("R5 empty after stop", r, DW'(exp_status(0, 1, 1, 0, 0)));

    // R7 R8 receive
    rx_send(8'h96, 1);
    rd(2, r); check("R7 rx ready", r, DW'(exp_status(1, 1, 1, 0, 0)));
    rd(0, r); check("R7 rx data", r, 32'h96);
    rd(2, r); check("R8 cleared", r, DW'(exp_status(0, 1, 1, 0, 0)));

    // R9 overrun
    rx_send(8'h11, 1);
    rx_send(8'h2E, 1);
    rd(2, r); check("R9 overrun set", r, DW'(exp_status(1, 1, 1, 1, 0)));
    rd(0, r); check("R9 newest byte", r, 32'h2E);
    wr(2, 0);
    rd(2, r); check("R9 cleared by write", r, DW'(exp_status(0, 1, 1, 0, 0)));

    // R10 glitch rejection
    set_div(15);
    @(negedge clk); rxd = 0;
    @(negedge clk); rxd = 1;
    repeat (40) @(negedge clk);
    rd(2, r); check("R10 glitch ignored", r, DW'(exp_status(0, 1, 1, 0, 0)));

    // R11 framing error
    rx_send(8'h5A, 0);
    repeat (60) @(negedge clk);
    rd(2, r); check("R11 frame error", r, DW'(exp_status(1, 1, 1, 0, 1)));
    rd(0, r); check("R11 byte stored", r, 32'h5A);
    wr(2, 0);
    rd(2, r); check("R9 ferr cleared", r, DW'(exp_status(0, 1, 1, 0, 0)));

    // R3 R7 random bytes over random divisors
    for (int k = 0; k < 12; k++) begin
      int d;
      d = 3 + int'($urandom_range(0, 12));
      set_div(d);
      rd(4, r); check("R1 divisor readback", r, DW'(d));
      b1 = 8'($urandom);
      fork
        tx_capture(rb, sv1);
        wr(1, DW'(b1));
      join
      check("R3 random frame", rb, b1);
      check("R3 random stop", sv1, 1);
      b2 = 8'($urandom);
      rx_send(b2, 1);
      rd(0, r); check("R7 random rx", r, DW'(b2));
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule